// File: doc/BRIEF.md
# Two-Register Top-of-Stack Cache

This block is a hardware operand stack. Its two newest entries live in two registers, called A and B. Older entries sit in a stack that grows upward in a single-port synchronous RAM. A 2-bit occupancy state records how many of the two registers hold live entries. Requests are served from the registers whenever they can be. An entry is spilled to memory only when a push arrives while both registers are full. An entry is filled from memory only when a request needs an entry that is not cached. As a result, alternating pushes and pops cost no memory cycles.

A requester drives one of four operations on a valid/ready port and holds it until ready is seen high:
- push a word;
- pop the top word;
- binary operation: presents the top and the entry below it to an external ALU and keeps the ALU result as the new top;
- branch: presents the same two entries as target (top) and condition (below) and discards both.

While a fill is in progress, ready stays low. Instruction decoding and the ALU itself live outside the block.

Top module: `tos_cache`

## Requirements
- R1: A synchronous reset sets `sp` to the parameter `BASE`, clears `out_valid`, and empties the cache, so a pop is not ready in the first cycle after reset.
- R2: Operation codes on `req_op` are 0 push, 1 pop, 2 binary operation, 3 branch; a push is always ready in the cycle it is presented.
- R3: A push into an empty or half-full cache makes no memory access and leaves `sp` unchanged.
- R4: A push into a full cache writes the lower cached entry (B) to memory at `sp`, increments `sp` and keeps both older entries retrievable in order.
- R5: A pop with at least one cached entry is ready in the same cycle, makes no memory access, and in the next cycle raises `out_valid` for one cycle with the popped word on `out_data`.
- R6: A pop on an empty cache holds ready low for exactly one cycle. During that cycle it reads memory at `sp`-1 and decrements `sp`. It then returns the word read, and the cache stays empty.
- R7: A binary operation drives the top entry on `opnd_top` and the entry below on `opnd_below` in its accepting cycle. `alu_result` then becomes the only cached entry, and the stack depth drops by one.
- R8: A binary operation or branch missing k cached entries (k = 0, 1 or 2) holds ready low for k cycles and performs k fills, one per cycle.
- R9: A branch presents target on `opnd_top` and condition on `opnd_below`, removes both entries and leaves the cache empty.
- R10: Starting from an empty cache, the sequence push, push, binary, push, binary makes no memory access.
- R11: At most one memory access occurs per cycle. A write occurs only for an accepted push, and a stalled request always issues a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation code (0 push, 1 pop, 2 binary, 3 branch) |
| req_data | input | DW | Word to push |
| req_ready | output | 1 | Request accepted at this clock edge when high with valid |
| out_valid | output | 1 | Pop result valid (one cycle after acceptance) |
| out_data | output | DW | Popped word |
| opnd_top | output | DW | Top entry for the binary operation or branch target |
| opnd_below | output | DW | Entry below top, or branch condition |
| alu_result | input | DW | ALU result for the binary operation, combinational from the operands |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (spill) when high, read (fill) when low |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Spill data |
| mem_rdata | input | DW | Read data, valid one cycle after a read |
| sp | output | AW | Stack pointer: next free memory slot |

## Verification
Two functions can coincide in one cycle. When a binary operation or branch arrives at an empty cache, the second cycle absorbs the data of the first fill into B and also issues the second fill. When one entry is missing, the cycle that delivers fill data is the same cycle that feeds the ALU and accepts the request. A seeded random mix of operations is generated with the occupancy steered through all three states, so both overlaps occur many times. Each one is judged against a bench stack model on the stall count, the memory access count, the operands shown to the ALU, `sp`, and the words later popped back.

// File: rtl/tos_pkg.sv
package tos_pkg;
   typedef enum logic [1:0] {
      OP_PUSH   = 2'd0,
      OP_POP    = 2'd1,
      OP_BINARY = 2'd2,
      OP_BRANCH = 2'd3
   } tos_op_t;

   typedef enum logic [1:0] {
      OCC_EMPTY = 2'd0,
      OCC_ONE   = 2'd1,
      OCC_TWO   = 2'd2
   } tos_occ_t;

   function automatic logic [1:0] op_need(input tos_op_t op);
      case (op)
         OP_PUSH: op_need = 2'd0;
         OP_POP:  op_need = 2'd1;
         default: op_need = 2'd2;
      endcase
   endfunction
endpackage

// File: rtl/tos_view.sv
module tos_view
   import tos_pkg::*;
#(
   parameter int DW = 16
) (
   input  tos_occ_t        occ,
   input  logic            fill_pend,
   input  logic [DW-1:0]   reg_a,
   input  logic [DW-1:0]   reg_b,
   input  logic [DW-1:0]   rdata,
   input  tos_op_t         op,
   output logic [DW-1:0]   top,
   output logic [DW-1:0]   below,
   output logic            enough
);
   logic [1:0] avail;

   always_comb begin
      avail = occ + {1'b0, fill_pend};
      enough = (avail >= op_need(op));
      case (occ)
         OCC_TWO: begin top = reg_a; below = reg_b; end
         OCC_ONE: begin top = reg_b; below = rdata; end
         default: begin top = rdata; below = rdata; end
      endcase
   end
endmodule

// File: rtl/tos_spport.sv
module tos_spport #(
   parameter int          DW   = 16,
   parameter int          AW   = 8,
   parameter logic [AW-1:0] BASE = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          spill,
   input  logic          fill,
   input  logic [DW-1:0] spill_data,
   output logic [AW-1:0] sp,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata
);
   logic [AW-1:0] sp_q;
   logic [AW-1:0] sp_dec;

   assign sp_dec    = sp_q - 1'b1;
   assign sp        = sp_q;
   assign mem_en    = spill | fill;
   assign mem_we    = spill;
   assign mem_addr  = spill ? sp_q : sp_dec;
   assign mem_wdata = spill_data;

   always_ff @(posedge clk) begin
      if (rst)        sp_q <= BASE;
      else if (spill) sp_q <= sp_q + 1'b1;
      else if (fill)  sp_q <= sp_dec;
   end
endmodule

// File: rtl/tos_cache.sv
module tos_cache
   import tos_pkg::*;
#(
   parameter int            DW   = 16,
   parameter int            AW   = 8,
   parameter logic [AW-1:0] BASE = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [DW-1:0] req_data,
   output logic          req_ready,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic [DW-1:0] opnd_top,
   output logic [DW-1:0] opnd_below,
   input  logic [DW-1:0] alu_result,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] sp
);
   localparam int DEPTH_MAX = 1 << AW;

   generate
      if (DW < 1) begin : g_bad_dw
         $error("tos_cache: DW must be at least 1");
      end
      if (AW < 2 || DEPTH_MAX < 4) begin : g_bad_aw
         $error("tos_cache: AW must be at least 2");
      end
   endgenerate

   tos_op_t       op;
   tos_occ_t      occ_q;
   logic          pend_q;
   logic [DW-1:0] a_q, b_q;
   logic [DW-1:0] top, below;
   logic          enough, accept, spill, fill;

   assign op = tos_op_t'(req_op);

   tos_view #(.DW(DW)) u_view (
      .occ(occ_q), .fill_pend(pend_q), .reg_a(a_q), .reg_b(b_q),
      .rdata(mem_rdata), .op(op), .top(top), .below(below), .enough(enough)
   );

   assign req_ready  = enough;
   assign accept     = req_valid & enough;
   assign spill      = accept & (op == OP_PUSH) & (occ_q == OCC_TWO);
   assign fill       = req_valid & ~enough;
   assign opnd_top   = top;
   assign opnd_below = below;

   tos_spport #(.DW(DW), .AW(AW), .BASE(BASE)) u_sp (
      .clk(clk), .rst(rst), .spill(spill), .fill(fill), .spill_data(b_q),
      .sp(sp), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         occ_q     <= OCC_EMPTY;
         pend_q    <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         a_q       <= '0;
         b_q       <= '0;
      end else begin
         pend_q    <= fill;
         out_valid <= accept & (op == OP_POP);
         if (accept) begin
            case (op)
               OP_PUSH: begin
                  case (occ_q)
                     OCC_EMPTY: begin b_q <= req_data; occ_q <= OCC_ONE; end
                     OCC_ONE:   begin a_q <= req_data; occ_q <= OCC_TWO; end
                     default:   begin b_q <= a_q; a_q <= req_data; end
                  endcase
               end
               OP_POP: begin
                  out_data <= top;
                  occ_q    <= (occ_q == OCC_TWO) ? OCC_ONE : OCC_EMPTY;
               end
               OP_BINARY: begin
                  b_q   <= alu_result;
                  occ_q <= OCC_ONE;
               end
               default: occ_q <= OCC_EMPTY;
            endcase
         end else if (fill && pend_q) begin
            b_q   <= mem_rdata;
            occ_q <= OCC_ONE;
         end
      end
   end
endmodule

// File: rtl/tos_cache_chk.sv
module tos_cache_chk #(
   parameter int DW = 16,
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          req_valid,
   input logic [1:0]    req_op,
   input logic          req_ready,
   input logic          out_valid,
   input logic          mem_en,
   input logic          mem_we,
   input logic [AW-1:0] sp
);
   a_r2_push_ready: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_op == 2'd0) |-> req_ready);

   a_r11_write_only_push: assert property (@(posedge clk) disable iff (rst)
      (mem_en && mem_we) |-> (req_valid && req_ready && req_op == 2'd0));

   a_r11_stall_reads: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_ready) |-> (mem_en && !mem_we));

   a_r4_sp_up: assert property (@(posedge clk) disable iff (rst)
      (mem_en && mem_we) |=> (sp == $past(sp) + 1'b1));

   a_r6_sp_down: assert property (@(posedge clk) disable iff (rst)
      (mem_en && !mem_we) |=> (sp == $past(sp) - 1'b1));

   a_r3_sp_hold: assert property (@(posedge clk) disable iff (rst)
      !mem_en |=> $stable(sp));

   a_r5_pop_output: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && req_op == 2'd1) |=> out_valid);
endmodule

bind tos_cache tos_cache_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
   .req_ready(req_ready), .out_valid(out_valid), .mem_en(mem_en),
   .mem_we(mem_we), .sp(sp)
);

// File: tb/tos_cache_tb.sv
`timescale 1ns/1ps
module tos_cache_tb;
   localparam int DW = 16;
   localparam int AW = 8;
   localparam logic [AW-1:0] BASE = 8'd16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [DW-1:0] req_data = '0;
   logic          req_ready, out_valid, mem_en, mem_we;
   logic [DW-1:0] out_data, opnd_top, opnd_below, alu_result, mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic [AW-1:0] mem_addr, sp;

   logic [DW-1:0] ram [0:(1<<AW)-1];
   logic [DW-1:0] mdl [0:(1<<AW)-1];
   int depth = 0, mc = 0, memcnt = 0, checks = 0, errors = 0;

   always #2 clk = ~clk;

   assign alu_result = opnd_top - opnd_below;

   always @(posedge clk) begin
      if (mem_en) begin
         memcnt = memcnt + 1;
         if (mem_we) ram[mem_addr] <= mem_wdata;
         else        mem_rdata     <= ram[mem_addr];
      end
   end

   tos_cache #(.DW(DW), .AW(AW), .BASE(BASE)) u_dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
      .req_data(req_data), .req_ready(req_ready), .out_valid(out_valid),
      .out_data(out_data), .opnd_top(opnd_top), .opnd_below(opnd_below),
      .alu_result(alu_result), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .sp(sp)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int need_of(input int op);
      return (op == 0) ? 0 : (op == 1) ? 1 : 2;
   endfunction

   function automatic int next_mc(input int op, input int c);
      case (op)
         0: return (c < 2) ? c + 1 : 2;
         1: return (c == 2) ? 1 : 0;
         2: return 1;
         default: return 0;
      endcase
   endfunction

   task automatic do_req(input int op, input logic [DW-1:0] d);
      int miss, w, m0, spills;
      logic [DW-1:0] t, b;
      miss   = need_of(op) - mc;
      if (miss < 0) miss = 0;
      spills = (op == 0 && mc == 2) ? 1 : 0;
      m0 = memcnt;
      @(negedge clk);
      req_valid = 1'b1; req_op = op[1:0]; req_data = d;
      #1;
      w = 0;
      while (!req_ready && w < 8) begin
         @(negedge clk); #1; w++;
      end
      if (op >= 2) begin
         check(w == miss, "R8", "stall cycles", w, miss);
         check(opnd_top == mdl[depth-1], op == 2 ? "R7" : "R9", "top operand",
               opnd_top, mdl[depth-1]);
         check(opnd_below == mdl[depth-2], op == 2 ? "R7" : "R9", "below operand",
               opnd_below, mdl[depth-2]);
      end else if (op == 1) begin
         check(w == miss, miss ? "R6" : "R5", "pop stall cycles", w, miss);
      end else begin
         check(w == 0, "R2", "push stall", w, 0);
      end
      t = opnd_top; b = opnd_below;
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      check(memcnt - m0 == miss + spills, "R11", "memory accesses",
            memcnt - m0, miss + spills);
      case (op)
         0: begin mdl[depth] = d; depth++; end
         1: begin
            depth--;
            check(out_valid == 1'b1, "R5", "out_valid", out_valid, 1);
            check(out_data == mdl[depth], miss ? "R6" : "R5", "pop data",
                  out_data, mdl[depth]);
         end
         2: begin depth--; mdl[depth-1] = t - b; end
         default: depth -= 2;
      endcase
      mc = next_mc(op, mc);
      if (mc > depth) mc = depth;
      check(sp == BASE + AW'(depth - mc), op == 0 ? (spills ? "R4" : "R3") : "R8",
            "stack pointer", sp, BASE + depth - mc);
      @(negedge clk); #1;
      if (op == 1) check(out_valid == 1'b0, "R5", "out_valid one cycle", out_valid, 0);
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int m0, op, sel;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      req_op = 2'd1;
      #1;
      check(sp == BASE, "R1", "sp after reset", sp, BASE);
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(req_ready == 1'b0, "R1", "pop ready on empty", req_ready, 0);
      req_op = 2'd0; #1;
      check(req_ready == 1'b1, "R2", "push ready idle", req_ready, 1);

      // R10: no memory traffic for push push binary push binary
      m0 = memcnt;
      do_req(0, 16'd7); do_req(0, 16'd30); do_req(2, 0);
      do_req(0, 16'd5); do_req(2, 0);
      check(memcnt == m0, "R10", "sequence traffic", memcnt - m0, 0);
      do_req(1, 0);

      // R4 spill, then R6 pops from an empty cache, R8 binary on empty
      do_req(0, 16'd100); do_req(0, 16'd200); do_req(0, 16'd300);
      do_req(0, 16'd400); do_req(0, 16'd500);
      do_req(1, 0); do_req(1, 0); do_req(1, 0); do_req(1, 0);
      do_req(0, 16'd11); do_req(0, 16'd22); do_req(0, 16'd33);
      do_req(3, 0); do_req(2, 0); do_req(1, 0);

      for (int i = 0; i < 1500; i++) begin
         sel = $urandom_range(0, 9);
         op = (sel < 4) ? 0 : (sel < 7) ? 1 : (sel < 9) ? 2 : 3;
         if (depth < need_of(op)) op = 0;
         if (depth > 200 && op == 0) op = 1;
         do_req(op, DW'($urandom));
      end
      while (depth > 0) do_req(1, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule